// File: doc/BRIEF.md
# I2C Channel-Select Target

This block is an I2C target that decides which of four downstream bus channels are connected. It oversamples SCL and SDA with a system clock, recognises START and STOP, and answers to a 7-bit address made of a fixed five-bit prefix followed by two strap pins. A write to the block loads a channel-selection byte. A read returns one byte that combines the live interrupt status of the four channels with the selection currently in force. SDA is driven only through an open-drain enable, and the block never drives SCL.

A host selects channels by writing a byte whose low nibble enables channels 3..0. The new selection is held back until the host ends the transfer with STOP, so a channel is never connected in the middle of a transaction. To find out which channel raised an interrupt, the host reads the byte and then writes a selection that opens the channel concerned. The interrupt vector comes from a separate filter block and is active high.

Top module: `i2c_chan_select`

## Requirements
- R1: After reset, `chan_en` is 4'b0000 and `sda_oe` is 0, so SDA is released.
- R2: The block acknowledges an address byte whose upper seven bits are 1,1,1,0,0,`strap[1]`,`strap[0]` (MSB first). It does so by setting `sda_oe` to 1 through the ninth clock. Bit 0 of the address byte selects the direction: 1 means read and 0 means write.
- R3: In a write, every data byte that follows an acknowledged address is acknowledged. Its bits 3:0 are kept as the pending selection.
- R4: `chan_en` takes the pending selection only when a STOP is seen. Before the STOP it keeps its previous value.
- R5: When a write carries several data bytes, only the last one reaches `chan_en` at STOP.
- R6: A read shifts out one byte, MSB first. Bits 7:4 are the interrupt status of channels 3..0, so bit 4 is channel 0 and 1 means an interrupt is pending. Bits 3:0 are the selection currently on `chan_en`.
- R7: The interrupt nibble is captured when the read address is acknowledged. A later change on `irq_status` does not alter the byte being shifted out.
- R8: After a not-acknowledge from the master following a read byte, `sda_oe` stays 0 until the next START or STOP.
- R9: A repeated START discards any pending selection that no STOP has committed, and address reception begins again.
- R10: After an address that does not match, the block gives no acknowledge. Data bytes that follow are neither acknowledged nor stored, up to the next START or STOP.
- R11: `sda_oe` changes only while SCL is low. It never changes during the high phase of a clock.
- R12: Asserting `rst_n` low in the middle of a transfer clears `chan_en` to 0, releases SDA and returns the bus logic to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap | input | 2 | Address strap pins; they form the two low bits of the 7-bit address |
| irq_status | input | 4 | Filtered interrupt status per channel; 1 means pending |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| chan_en | output | 4 | Channel enable vector; bit n connects channel n |

## Verification
A corrupted bit counter or a wrong state shows up on the bus within one byte time. Either the acknowledge is missing or misplaced on the ninth clock, or the read byte comes out shifted. A fault in the pending/commit path does not show while the write is in progress. It appears at the STOP that follows, as a wrong `chan_en` value, or as a change before the STOP, or as a value that survives a repeated START when it should have been dropped. Stale interrupt capture shows up in the upper nibble of the very next read.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_AACK,
        BUS_WDAT,
        BUS_WACK,
        BUS_RDAT,
        BUS_RACK,
        BUS_SKIP
    } bus_st_e;

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);
    localparam int LINES = 2;
    localparam int SCL_IX = 1;
    localparam int SDA_IX = 0;

    logic [LINES-1:0]           line_in;
    logic [LINES-1:0][STAGES:0] chain_d, chain_q;

    assign line_in = {scl_i, sda_i};

    // one chain per line: STAGES synchronizer flops plus one history flop
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign chain_d[g] = {chain_q[g][STAGES-1:0], line_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    logic scl_cur, scl_old, sda_cur, sda_old;
    assign scl_cur = chain_q[SCL_IX][STAGES-1];
    assign scl_old = chain_q[SCL_IX][STAGES];
    assign sda_cur = chain_q[SDA_IX][STAGES-1];
    assign sda_old = chain_q[SDA_IX][STAGES];

    assign sda_s   = sda_cur;
    assign start_p = scl_cur & scl_old & sda_old & ~sda_cur;
    assign stop_p  = scl_cur & scl_old & ~sda_old & sda_cur;
    assign rise_p  = scl_cur & ~scl_old;
    assign fall_p  = ~scl_cur & scl_old;

endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
    import chsel_pkg::*;
#(
    parameter int            CH_N  = 4,
    parameter int            PFX_W = 5,
    parameter logic [PFX_W-1:0] PFX = 5'b11100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_p,
    input  logic                 stop_p,
    input  logic                 rise_p,
    input  logic                 fall_p,
    input  logic                 sda_s,
    input  logic [DATA_W-PFX_W-2:0] strap,
    input  logic [CH_N-1:0]      irq,
    input  logic [CH_N-1:0]      cur_sel,
    output logic                 sda_oe,
    output logic                 wr_p,
    output logic [CH_N-1:0]      wr_sel
);
    localparam int DATA_W  = 2 * CH_N;
    localparam int STRAP_W = DATA_W - PFX_W - 1;
    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        bus_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  sh;
        logic [DATA_W-1:0]  tx;
        logic [DATA_W-1:0]  hold;
        logic               rw;
        logic               oe;
        logic               mack;
        logic               wr;
        logic [CH_N-1:0]    wsel;
    } ctrl_t;

    ctrl_t d, q;

    logic [DATA_W-2:0] my_addr;
    assign my_addr = {PFX, strap[STRAP_W-1:0]};

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (stop_p) begin
            d.st = BUS_IDLE;
            d.oe = 1'b0;
        end else if (start_p) begin
            d.st  = BUS_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                BUS_ADDR: begin
                    if (rise_p) begin
                        d.sh  = {q.sh[DATA_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_p && q.cnt == CNT_FULL) begin
                        if (q.sh[DATA_W-1:1] == my_addr) begin
                            d.st = BUS_AACK;
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                            if (q.sh[0]) d.hold = {irq, cur_sel};
                        end else begin
                            d.st = BUS_SKIP;
                        end
                    end
                end
                BUS_AACK: begin
                    if (fall_p) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = BUS_RDAT;
                            d.tx = q.hold;
                            d.oe = ~q.hold[DATA_W-1];
                        end else begin
                            d.st = BUS_WDAT;
                            d.oe = 1'b0;
                        end
                    end
                end
                BUS_WDAT: begin
                    if (rise_p) begin
                        d.sh  = {q.sh[DATA_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_p && q.cnt == CNT_FULL) begin
                        d.st   = BUS_WACK;
                        d.oe   = 1'b1;
                        d.wr   = 1'b1;
                        d.wsel = q.sh[CH_N-1:0];
                    end
                end
                BUS_WACK: begin
                    if (fall_p) begin
                        d.st  = BUS_WDAT;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                    end
                end
                BUS_RDAT: begin
                    if (fall_p) begin
                        d.cnt = q.cnt + 1'b1;
                        d.tx  = {q.tx[DATA_W-2:0], 1'b0};
                        if (q.cnt == CNT_LAST) begin
                            d.st = BUS_RACK;
                            d.oe = 1'b0;
                        end else begin
                            d.oe = ~q.tx[DATA_W-2];
                        end
                    end
                end
                BUS_RACK: begin
                    if (rise_p) begin
                        d.mack = ~sda_s;
                    end else if (fall_p) begin
                        if (q.mack) begin
                            d.st  = BUS_RDAT;
                            d.cnt = '0;
                            d.tx  = q.hold;
                            d.oe  = ~q.hold[DATA_W-1];
                        end else begin
                            d.st = BUS_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: BUS_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign wr_p   = q.wr;
    assign wr_sel = q.wsel;

    // R11
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(fall_p || start_p || stop_p));

    // R8 R10
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BUS_SKIP) |-> !q.oe);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BUS_RDAT || q.st == BUS_RACK) |-> $stable(q.hold));

endmodule

// File: rtl/chsel_sel.sv
module chsel_sel #(
    parameter int CH_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_p,
    input  logic [CH_N-1:0] wr_sel,
    input  logic            start_p,
    input  logic            stop_p,
    output logic [CH_N-1:0] sel
);
    typedef struct packed {
        logic [CH_N-1:0] pend;
        logic            pend_v;
        logic [CH_N-1:0] sel;
    } sel_t;

    sel_t d, q;

    always_comb begin
        d = q;
        if (wr_p) begin
            d.pend   = wr_sel;
            d.pend_v = 1'b1;
        end
        if (start_p) begin
            d.pend_v = 1'b0;
        end
        if (stop_p && q.pend_v) begin
            d.sel    = q.pend;
            d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel = q.sel;

    // R4
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sel) |-> $past(stop_p));

    // R9
    start_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_p) && !$past(wr_p) |-> !q.pend_v);

endmodule

// File: rtl/i2c_chan_select.sv
module i2c_chan_select #(
    parameter int               CH_N        = 4,
    parameter int               PFX_W       = 5,
    parameter logic [PFX_W-1:0] PFX         = 5'b11100,
    parameter int               SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [1:0]      strap,
    input  logic [CH_N-1:0] irq_status,
    output logic            sda_oe,
    output logic [CH_N-1:0] chan_en
);
    logic sda_s, start_p, stop_p, rise_p, fall_p;
    logic wr_p;
    logic [CH_N-1:0] wr_sel;
    logic [CH_N-1:0] sel;

    chsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_s   (sda_s),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    chsel_ctrl #(.CH_N(CH_N), .PFX_W(PFX_W), .PFX(PFX)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .sda_s   (sda_s),
        .strap   (strap),
        .irq     (irq_status),
        .cur_sel (sel),
        .sda_oe  (sda_oe),
        .wr_p    (wr_p),
        .wr_sel  (wr_sel)
    );

    chsel_sel #(.CH_N(CH_N)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_p    (wr_p),
        .wr_sel  (wr_sel),
        .start_p (start_p),
        .stop_p  (stop_p),
        .sel     (sel)
    );

    assign chan_en = sel;

    // R1 R12
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> (chan_en == '0) && !sda_oe);

endmodule

// File: tb/tb_i2c_chan_select.sv
module tb_i2c_chan_select;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic m_scl, m_sda;
    logic [1:0] strap;
    logic [3:0] irq_status;
    logic sda_oe;
    logic [3:0] chan_en;
    logic sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_chan_select dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .strap      (strap),
        .irq_status (irq_status),
        .sda_oe     (sda_oe),
        .chan_en    (chan_en)
    );

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [3:0] sel_m;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rw);
        return {5'b11100, s, rw};
    endfunction

    function automatic logic [7:0] read_exp(input logic [3:0] irq, input logic [3:0] sel);
        return {irq, sel};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        acked = ~sda_bus;
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b, output logic steady);
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q);
            m_scl = 1'b1; wq(2);
            b[i] = sda_bus;
            wq(2*Q-2);
            if (sda_bus !== b[i]) steady = 1'b0;
            m_scl = 1'b0; wq(Q);
        end
        m_sda = nack; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [1:0] s, input logic [7:0] data[$], input logic do_stop);
        logic a;
        bus_start();
        send_byte(addr_byte(s, 1'b0), a);
        chk(a === (s == strap), "R2 address ack", a, (s == strap));
        foreach (data[k]) begin
            send_byte(data[k], a);
            if (s == strap) chk(a === 1'b1, "R3 data ack", a, 1);
            else            chk(a === 1'b0, "R10 no ack after mismatch", a, 0);
        end
        chk(chan_en === sel_m, "R4 no change before STOP", chan_en, sel_m);
        if (do_stop) begin
            bus_stop();
            if (s == strap && data.size() > 0) sel_m = data[data.size()-1][3:0];
            chk(chan_en === sel_m, "R4 R5 selection after STOP", chan_en, sel_m);
        end
    endtask

    task automatic do_read(input logic [3:0] irq_at_addr, input logic [3:0] irq_later);
        logic a, st;
        logic [7:0] b;
        logic [7:0] e;
        irq_status = irq_at_addr;
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a === 1'b1, "R2 read address ack", a, 1);
        e = read_exp(irq_at_addr, sel_m);
        irq_status = irq_later;
        read_byte(1'b1, b, st);
        chk(b === e, "R6 R7 read byte", b, e);
        chk(st === 1'b1, "R11 SDA steady while SCL high", st, 1);
        m_sda = 1'b0;
        wq(2);
        m_scl = 1'b1;
        wq(Q);
        chk(sda_oe === 1'b0, "R8 released after NACK", sda_oe, 0);
        m_sda = 1'b1; wq(Q);
    endtask

    initial begin
        logic [7:0] q[$];
        logic a;
        void'($urandom(32'h1C2A5));
        m_scl = 1'b1; m_sda = 1'b1;
        strap = 2'b10; irq_status = '0;
        sel_m = '0;
        rst_n = 1'b0;
        wq(5);
        chk(chan_en === 4'h0, "R1 chan_en reset", chan_en, 0);
        chk(sda_oe === 1'b0, "R1 sda_oe reset", sda_oe, 0);
        rst_n = 1'b1;
        wq(5);

        // R3 R4 single write
        q = '{8'h05};
        do_write(strap, q, 1'b1);
        // R5 last of several bytes
        q = '{8'h03, 8'hFC, 8'h09};
        do_write(strap, q, 1'b1);
        // R6
        do_read(4'b1010, 4'b1010);
        // R7 interrupt change after address ack
        do_read(4'b0011, 4'b1100);

        // R9 repeated start drops pending write
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h0F, a);
        do_read(4'b0001, 4'b0001);
        chk(chan_en === sel_m, "R9 pending dropped by repeated START", chan_en, sel_m);

        // R10 mismatched strap and prefix
        q = '{8'h00, 8'h0E};
        do_write(2'b01, q, 1'b1);
        chk(chan_en === sel_m, "R10 mismatch ignored", chan_en, sel_m);
        bus_start();
        send_byte(8'b1101_0100, a);
        chk(a === 1'b0, "R10 wrong prefix no ack", a, 0);
        send_byte(8'h00, a);
        bus_stop();
        chk(chan_en === sel_m, "R10 wrong prefix no effect", chan_en, sel_m);

        // R12 reset mid-transfer
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h06, a);
        wq(2);
        rst_n = 1'b0; wq(3);
        chk(chan_en === 4'h0, "R12 chan_en cleared", chan_en, 0);
        chk(sda_oe === 1'b0, "R12 SDA released", sda_oe, 0);
        rst_n = 1'b1; wq(3);
        sel_m = '0;
        bus_stop();
        chk(chan_en === 4'h0, "R12 nothing commits after reset", chan_en, 0);

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            int nb;
            kind = $urandom % 4;
            if (kind < 2) begin
                q = {};
                nb = 1 + ($urandom % 3);
                for (int k = 0; k < nb; k++) q.push_back(8'($urandom));
                do_write(strap, q, 1'b1);
            end else if (kind == 2) begin
                do_read(4'($urandom), 4'($urandom));
            end else begin
                q = '{8'($urandom)};
                do_write(strap ^ 2'($urandom % 3 + 1), q, 1'b1);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule